// File: doc/BRIEF.md
# Supervisory Timeout Timer

This block measures acknowledgement-supervision intervals for a serial link controller. A configuration write loads a period value, picks one of two prescale bases (a coarse base and a fine base) and picks who may start the timer. Once started, the timer counts (VALUE+1) whole prescale periods and then raises a sticky timeout interrupt.

Two start sources exist. In processor-driven mode only the processor's start strobe is honoured. In link-driven mode only the strobe from the frame-sequencing logic is honoured, as needed when the controller itself sends numbered frames and supervises their acknowledgement. A start while the timer runs begins a fresh full period. Any configuration write stops a running timer. The interrupt remains set until a clear strobe arrives.

All pins are plain control and status levels or single-cycle strobes; no data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `sup_timer`

## Requirements
- R1: After reset `irq` and `running` are 0, the stored period value is 0, the coarse base is selected and processor-driven mode is active.
- R2: With period value V and base B, an accepted start sampled at clock edge E makes `irq` rise and `running` fall at edge E+(V+1)*B exactly, and not earlier.
- R3: `cfg_fine`=1 selects base FINE_DIV; `cfg_fine`=0 selects base COARSE_DIV.
- R4: With `cfg_internal`=0 (processor-driven), `cpu_start` starts the timer and `proto_start` has no effect.
- R5: With `cfg_internal`=1 (link-driven), `proto_start` starts the timer and `cpu_start` has no effect.
- R6: An accepted start while the timer runs restarts both the prescaler and the period count, so expiry comes (V+1)*B edges after the newer start.
- R7: A configuration write (`cfg_we`=1) clears `running` at the next edge and prevents the pending expiry; it wins over a start strobe in the same cycle.
- R8: `irq` stays 1 until `irq_clr` is sampled; if an expiry and `irq_clr` coincide, `irq` stays 1.
- R9: Starting the timer does not clear a pending `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; also stops the timer |
| cfg_value | input | VALUE_W | Period value V |
| cfg_fine | input | 1 | 1 = fine base, 0 = coarse base |
| cfg_internal | input | 1 | 1 = link-driven start, 0 = processor-driven start |
| cpu_start | input | 1 | Processor start strobe |
| proto_start | input | 1 | Link-logic start strobe |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Sticky timeout interrupt |
| running | output | 1 | Timer is counting |

## Verification
A prescaler that is not cleared on start, or a period counter off by one, moves the rising edge of `irq` by at least one clock and by up to a full base period, so every timed case measures the exact edge count from start to interrupt. A stale mode or a stop that fails to take effect shows as `running` staying high one cycle after the write or after an ignored strobe, and as an interrupt that appears when none is due; the bench watches both for a full period afterwards.

// File: rtl/sup_timer_pkg.sv
package sup_timer_pkg;
  typedef enum logic {
    TMR_EXT = 1'b0,
    TMR_INT = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    logic      fine;
    tmr_mode_e mode;
  } tmr_ctl_t;
endpackage

// File: rtl/sup_timer_prescale.sv
module sup_timer_prescale #(
  parameter int COARSE_DIV = 32768,
  parameter int FINE_DIV   = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic fine,
  output logic tick
);
  localparam int MAXDIV = (COARSE_DIV > FINE_DIV) ? COARSE_DIV : FINE_DIV;
  localparam int PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
  localparam logic [PW-1:0] C_LIM = PW'(COARSE_DIV - 1);
  localparam logic [PW-1:0] F_LIM = PW'(FINE_DIV - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;
  logic          wrap;

  assign lim = fine ? F_LIM : C_LIM;

  generate
    if (MAXDIV == 1) begin : g_trivial
      assign wrap = 1'b1;
    end else begin : g_cmp
      assign wrap = (cnt_q == lim);
    end
  endgenerate

  assign tick = enable && !clear && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || !enable) cnt_q <= '0;
    else if (wrap)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sup_timer_units.sv
module sup_timer_units #(
  parameter int VALUE_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [VALUE_W-1:0] load_val,
  input  logic               abort,
  input  logic               tick,
  output logic               running,
  output logic               expire
);
  logic [VALUE_W-1:0] left_q;
  logic               run_q;

  assign running = run_q;
  assign expire  = run_q && tick && (left_q == '0) && !load && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      left_q <= '0;
    end else if (abort) begin
      run_q  <= 1'b0;
    end else if (load) begin
      run_q  <= 1'b1;
      left_q <= load_val;
    end else if (run_q && tick) begin
      if (left_q == '0) run_q  <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/sup_timer_flag.sv
module sup_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/sup_timer.sv
module sup_timer
  import sup_timer_pkg::*;
#(
  parameter int VALUE_W    = 7,
  parameter int COARSE_DIV = 32768,
  parameter int FINE_DIV   = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [VALUE_W-1:0] cfg_value,
  input  logic               cfg_fine,
  input  logic               cfg_internal,
  input  logic               cpu_start,
  input  logic               proto_start,
  input  logic               irq_clr,
  output logic               irq,
  output logic               running
);
  logic [VALUE_W-1:0] value_q;
  tmr_ctl_t           ctl_q;
  logic               start_go;
  logic               tick_w;
  logic               expire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      ctl_q   <= '{fine: 1'b0, mode: TMR_EXT};
    end else if (cfg_we) begin
      value_q <= cfg_value;
      ctl_q   <= '{fine: cfg_fine, mode: tmr_mode_e'(cfg_internal)};
    end
  end

  assign start_go = (ctl_q.mode == TMR_INT) ? proto_start : cpu_start;

  sup_timer_prescale #(
    .COARSE_DIV(COARSE_DIV),
    .FINE_DIV  (FINE_DIV)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_go || cfg_we),
    .enable(running),
    .fine  (ctl_q.fine),
    .tick  (tick_w)
  );

  sup_timer_units #(
    .VALUE_W(VALUE_W)
  ) u_units (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_go),
    .load_val(value_q),
    .abort   (cfg_we),
    .tick    (tick_w),
    .running (running),
    .expire  (expire_w)
  );

  sup_timer_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (expire_w),
    .clr  (irq_clr),
    .flag (irq)
  );
endmodule

// File: rtl/sup_timer_chk.sv
module sup_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cpu_start,
  input logic proto_start,
  input logic irq_clr,
  input logic irq,
  input logic running,
  input logic mode_int,
  input logic start_go,
  input logic expire_w
);
  a_r7_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !running);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r2_expire_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (irq && !running));

  a_r4_proto_ignored_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_int && proto_start && !cpu_start && !running && !cfg_we) |=> !running);

  a_r5_cpu_ignored_int: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_int && cpu_start && !proto_start && !running && !cfg_we) |=> !running);

  a_r6_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !cfg_we) |=> running);

  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(running));
endmodule

bind sup_timer sup_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cpu_start  (cpu_start),
  .proto_start(proto_start),
  .irq_clr    (irq_clr),
  .irq        (irq),
  .running    (running),
  .mode_int   (ctl_q.mode == sup_timer_pkg::TMR_INT),
  .start_go   (start_go),
  .expire_w   (expire_w)
);

// File: tb/sup_timer_tb.sv
module sup_timer_tb;
  localparam int VW = 4;
  localparam int CD = 16;
  localparam int FD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_fine = 1'b0, cfg_internal = 1'b0;
  logic [VW-1:0] cfg_value = '0;
  logic cpu_start = 1'b0, proto_start = 1'b0, irq_clr = 1'b0;
  logic irq, running;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sup_timer #(.VALUE_W(VW), .COARSE_DIV(CD), .FINE_DIV(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_value(cfg_value),
    .cfg_fine(cfg_fine), .cfg_internal(cfg_internal), .cpu_start(cpu_start),
    .proto_start(proto_start), .irq_clr(irq_clr), .irq(irq), .running(running)
  );

  // bit7 internal mode, bit6 fine base, bit5 strobe (1 = proto_start), bits3:0 value
  localparam logic [7:0] VEC [8] = '{
    8'b0100_0000, 8'b0100_0011, 8'b0000_0010, 8'b1110_0101,
    8'b1010_0001, 8'b0110_0010, 8'b1100_0010, 8'b0100_1111
  };

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic configure(input logic intl, input logic fine, input logic [VW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_internal = intl; cfg_fine = fine; cfg_value = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic proto);
    @(negedge clk);
    if (proto) proto_start = 1'b1; else cpu_start = 1'b1;
    @(negedge clk);
    proto_start = 1'b0; cpu_start = 1'b0;
  endtask

  // counts edges after the start edge until irq is seen
  task automatic measure(input int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (!irq) n = -1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 running after reset", int'(running), 0);
    rst_n = 1'b1;
    // R1: default coarse base, value 0, processor-driven
    pulse_start(1'b0);
    measure(CD + 4, n);
    check("R1 default period", n, CD);
    clear_irq();

    foreach (VEC[i]) begin
      logic intl, fine, proto;
      int base, expn;
      intl = VEC[i][7]; fine = VEC[i][6]; proto = VEC[i][5];
      base = fine ? FD : CD;
      expn = (int'(VEC[i][3:0]) + 1) * base;
      configure(intl, fine, VEC[i][VW-1:0]);
      clear_irq();
      pulse_start(proto);
      if (intl == proto) begin
        check("R4/R5 started", int'(running), 1);
        measure(expn + 4, n);
        check("R2/R3 expiry edge", n, expn);
        check("R2 running falls", int'(running), 0);
      end else begin
        check(intl ? "R5 cpu_start ignored" : "R4 proto_start ignored", int'(running), 0);
        repeat (expn + 4) @(negedge clk);
        check(intl ? "R5 no irq" : "R4 no irq", int'(irq), 0);
      end
    end

    // R6: restart while running
    configure(1'b0, 1'b1, 4'd3);
    clear_irq();
    pulse_start(1'b0);
    repeat (9) @(negedge clk);
    pulse_start(1'b0);
    measure(40, n);
    check("R6 restart period", n, 16);

    // R9: start with irq pending keeps irq
    pulse_start(1'b0);
    check("R9 irq kept on start", int'(irq), 1);
    check("R9 running", int'(running), 1);
    clear_irq();

    // R7: write stops running timer
    repeat (3) @(negedge clk);
    configure(1'b0, 1'b1, 4'd3);
    check("R7 stopped by write", int'(running), 0);
    repeat (24) @(negedge clk);
    check("R7 no irq after stop", int'(irq), 0);

    // R7: write wins over start in same cycle
    @(negedge clk);
    cfg_we = 1'b1; cpu_start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cpu_start = 1'b0;
    check("R7 write beats start", int'(running), 0);

    // R8: sticky and set-beats-clear
    configure(1'b0, 1'b1, 4'd0);
    pulse_start(1'b0);
    repeat (3) @(negedge clk);
    check("R8 not yet", int'(irq), 0);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R8 set beats clear", int'(irq), 1);
    repeat (20) @(negedge clk);
    check("R8 sticky", int'(irq), 1);
    clear_irq();
    check("R8 cleared", int'(irq), 0);

    finish_run();
  end
endmodule